// File: doc/BRIEF.md
# Byte-Wide Boot Memory Loader

This block sequences a processor node out of reset. While reset is held it samples a single boot-select input. If that input is low, the node boots from an external byte-wide memory. The loader reads 1024 consecutive bytes from it, assembles every group of four bytes into one 32-bit word and writes 256 words into local instruction memory at word addresses 0 through 255. It then signals the core to begin execution at address zero. If the boot-select input is high, the block does nothing after reset. The node stays quiet, and a host or link agent outside this block fills its memory.

Each external read holds one byte address steady for a fixed number of wait cycles, set by a parameter. The data byte is captured in the last of those cycles. The memory is enabled only while bytes are being fetched. Asserting reset at any time abandons a load in progress, and the boot-select input is sampled again.

Top module: `bootrom_loader`

## Requirements
- R1: The boot-select input is sampled while `rst` is high. A low level selects memory boot, which begins in the first cycle after reset is released. A high level selects the idle path.
- R2: Changes of the boot-select input while `rst` is low have no effect on the chosen path or on a load in progress.
- R3: `rom_cs_n` is low only while a memory-boot load is fetching bytes. It is high during reset, in the idle path and after the load has finished.
- R4: `rom_addr` is 24 bits wide and steps through byte addresses 0 to 1023 in ascending order. Its upper bits stay zero. Each address is held for exactly WAIT_CYC+1 cycles, and `rom_data` is captured in the last of them.
- R5: Packing is little-endian. The byte at address 4k goes to bits [7:0] of word k, 4k+1 to [15:8], 4k+2 to [23:16] and 4k+3 to [31:24].
- R6: A memory-boot load makes exactly 256 single-cycle writes (`imem_we` high for one cycle), at word addresses 0 to 255 in ascending order.
- R7: `core_start` is a one-cycle pulse in the same cycle as the write to word 255. `core_run` is high from then on until the next reset, and `core_entry_pc` is 0x00000000.
- R8: In the idle path the block never writes, never pulses `core_start` and keeps `core_run` low.
- R9: A reset during a load abandons it. The next boot path follows the boot-select level present during that new reset, and a new memory boot starts again at byte 0 and word 0.
- R10: With reset released, `core_start` appears 1024*(WAIT_CYC+1) rising edges after the first edge at which `rst` is low, counting that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_sel | input | 1 | Boot path select, sampled during reset (0 = memory boot, 1 = idle) |
| rom_addr | output | 24 | External byte address |
| rom_cs_n | output | 1 | External memory enable, active low |
| rom_data | input | 8 | External memory read data |
| imem_we | output | 1 | Local instruction memory write strobe |
| imem_addr | output | 8 | Local word address |
| imem_wdata | output | 32 | Packed write data |
| core_start | output | 1 | One-cycle start pulse to the core |
| core_run | output | 1 | Level: core released after a memory boot |
| core_entry_pc | output | 32 | Start address for the core (zero) |

## Verification
The assertions check these properties on every cycle:
- The byte address stays steady between capture strobes.
- The memory enable is never low once the core runs.
- Writes are isolated single-cycle strobes.
- The start pulse lasts one cycle and always lands on the write of word 255.
- The idle path never enables the memory or writes.

Only the bench's scenarios can show the rest:
- The exact byte contents and their lane order.
- The total load latency.
- That the boot-select input is ignored outside reset.
- That an abort followed by a fresh memory boot restarts cleanly from word 0.

// File: rtl/bootld_pkg.sv
package bootld_pkg;

    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;

    typedef enum logic [1:0] {
        BL_HOLD  = 2'd0,
        BL_FETCH = 2'd1,
        BL_RUN   = 2'd2
    } bl_state_e;

    typedef struct packed {
        logic                  vld;
        logic [1:0]            lane;
        logic [BYTE_W-1:0]     data;
    } byte_beat_t;

    function automatic logic [1:0] lane_of(input logic [1:0] low_bits);
        return low_bits;
    endfunction

endpackage

// File: rtl/bootld_seq.sv
module bootld_seq
    import bootld_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int WORDS    = 256,
    parameter int WAIT_CYC = 2,
    localparam int BYTES   = WORDS * LANES,
    localparam int BC_W    = $clog2(BYTES),
    localparam int IDX_W   = $clog2(WORDS),
    localparam int WCNT_W  = $clog2(WAIT_CYC + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               strap,
    input  logic [BYTE_W-1:0]  rom_data,
    output logic [ADDR_W-1:0]  rom_addr,
    output logic               rom_cs_n,
    output byte_beat_t         beat,
    output logic [IDX_W-1:0]   word_idx,
    output logic               start,
    output logic               run,
    output logic               idle
);

    bl_state_e          state_q;
    logic [BC_W-1:0]    byte_q;
    logic [WCNT_W-1:0]  wait_q;
    logic               start_q;
    logic               sample;
    logic               last_byte;

    assign sample    = (state_q == BL_FETCH) && (wait_q == WCNT_W'(WAIT_CYC));
    assign last_byte = (byte_q == BC_W'(BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= strap ? BL_HOLD : BL_FETCH;
            byte_q  <= '0;
            wait_q  <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state_q)
                BL_FETCH: begin
                    if (sample) begin
                        wait_q <= '0;
                        byte_q <= byte_q + 1'b1;
                        if (last_byte) begin
                            state_q <= BL_RUN;
                            start_q <= 1'b1;
                        end
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign rom_addr  = {{(ADDR_W-BC_W){1'b0}}, byte_q};
    assign rom_cs_n  = rst || (state_q != BL_FETCH);
    assign beat.vld  = sample;
    assign beat.lane = lane_of(byte_q[1:0]);
    assign beat.data = rom_data;
    assign word_idx  = byte_q[BC_W-1:2];
    assign start     = start_q;
    assign run       = (state_q == BL_RUN);
    assign idle      = (state_q == BL_HOLD);

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rom_cs_n && !sample) |=> $stable(rom_addr));

    // R3
    cs_vs_run_chk: assert property (@(posedge clk) disable iff (rst)
        !rom_cs_n |-> !run);

    // R7
    start_width_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

endmodule

// File: rtl/bootld_packer.sv
module bootld_packer
    import bootld_pkg::*;
#(
    parameter int WORDS  = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  byte_beat_t         beat,
    input  logic [IDX_W-1:0]   word_idx,
    output logic               word_vld,
    output logic [IDX_W-1:0]   word_addr,
    output logic [WORD_W-1:0]  word_data
);

    logic [BYTE_W-1:0] lane_q [LANES-1];
    logic [WORD_W-1:0] packed_w;

    for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                lane_q[g] <= '0;
            else if (beat.vld && beat.lane == 2'(g))
                lane_q[g] <= beat.data;
        end
        assign packed_w[g*BYTE_W +: BYTE_W] = lane_q[g];
    end
    assign packed_w[(LANES-1)*BYTE_W +: BYTE_W] = beat.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_vld  <= 1'b0;
            word_addr <= '0;
            word_data <= '0;
        end else begin
            word_vld <= beat.vld && (beat.lane == 2'(LANES - 1));
            if (beat.vld && (beat.lane == 2'(LANES - 1))) begin
                word_addr <= word_idx;
                word_data <= packed_w;
            end
        end
    end

    // R6
    we_single_chk: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> !word_vld);

endmodule

// File: rtl/bootrom_loader.sv
module bootrom_loader
    import bootld_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int WORDS    = 256,
    parameter int WAIT_CYC = 2,
    localparam int IDX_W   = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               boot_sel,
    output logic [ADDR_W-1:0]  rom_addr,
    output logic               rom_cs_n,
    input  logic [7:0]         rom_data,
    output logic               imem_we,
    output logic [IDX_W-1:0]   imem_addr,
    output logic [31:0]        imem_wdata,
    output logic               core_start,
    output logic               core_run,
    output logic [31:0]        core_entry_pc
);

    byte_beat_t        beat;
    logic [IDX_W-1:0]  word_idx;
    logic              boot_idle;

    bootld_seq #(
        .ADDR_W   (ADDR_W),
        .WORDS    (WORDS),
        .WAIT_CYC (WAIT_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .strap    (boot_sel),
        .rom_data (rom_data),
        .rom_addr (rom_addr),
        .rom_cs_n (rom_cs_n),
        .beat     (beat),
        .word_idx (word_idx),
        .start    (core_start),
        .run      (core_run),
        .idle     (boot_idle)
    );

    bootld_packer #(
        .WORDS (WORDS)
    ) u_pack (
        .clk       (clk),
        .rst       (rst),
        .beat      (beat),
        .word_idx  (word_idx),
        .word_vld  (imem_we),
        .word_addr (imem_addr),
        .word_data (imem_wdata)
    );

    assign core_entry_pc = 32'h0000_0000;

    // R7
    start_on_last_chk: assert property (@(posedge clk) disable iff (rst)
        core_start |-> (imem_we && imem_addr == IDX_W'(WORDS - 1)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        boot_idle |-> (rom_cs_n && !imem_we && !core_start));

endmodule

// File: tb/sim_bootrom_loader.sv
module sim_bootrom_loader;

    localparam int WAIT     = 2;
    localparam int NWORDS   = 256;
    localparam int LOAD_CYC = NWORDS * 4 * (WAIT + 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_sel = 1'b0;
    logic [23:0] rom_addr;
    logic        rom_cs_n;
    logic [7:0]  rom_data;
    logic        imem_we;
    logic [7:0]  imem_addr;
    logic [31:0] imem_wdata;
    logic        core_start;
    logic        core_run;
    logic [31:0] core_entry_pc;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bootrom_loader #(.ADDR_W(24), .WORDS(NWORDS), .WAIT_CYC(WAIT)) u0 (
        .clk (clk), .rst (rst), .boot_sel (boot_sel),
        .rom_addr (rom_addr), .rom_cs_n (rom_cs_n), .rom_data (rom_data),
        .imem_we (imem_we), .imem_addr (imem_addr), .imem_wdata (imem_wdata),
        .core_start (core_start), .core_run (core_run),
        .core_entry_pc (core_entry_pc)
    );

    function automatic logic [7:0] rom_byte(input logic [23:0] a);
        return a[7:0] ^ {a[9:8], 6'b0} ^ 8'h5A;
    endfunction

    function automatic logic [31:0] exp_word(input int k);
        logic [23:0] b;
        b = 24'(k * 4);
        return {rom_byte(b + 3), rom_byte(b + 2), rom_byte(b + 1), rom_byte(b)};
    endfunction

    // memory model: data valid only after the address has been steady WAIT cycles
    logic [23:0] last_a = '0;
    int          stab = 0;
    always @(negedge clk) begin
        if (rom_addr != last_a) begin
            last_a <= rom_addr;
            stab   <= 0;
        end else if (stab < 15) begin
            stab <= stab + 1;
        end
    end
    assign rom_data = rom_cs_n ? 8'hEE :
                      (stab >= WAIT) ? rom_byte(last_a) : ~rom_byte(last_a);

    // write / address monitor
    logic        mon_clr = 1'b0;
    int          wr_cnt, wr_bad, cs_low, starts, hold_bad, seq_bad, hold_len;
    logic        prev_low;
    logic [23:0] prev_a, max_a;
    logic [31:0] seen [NWORDS];

    always @(negedge clk) begin
        if (mon_clr) begin
            wr_cnt = 0; wr_bad = 0; cs_low = 0; starts = 0;
            hold_bad = 0; seq_bad = 0; hold_len = 0;
            prev_low = 1'b0; prev_a = '0; max_a = '0;
        end else if (!rst) begin
            if (imem_we) begin
                seen[imem_addr] = imem_wdata;
                if (int'(imem_addr) != wr_cnt || imem_wdata != exp_word(int'(imem_addr)))
                    wr_bad++;
                wr_cnt++;
            end
            if (core_start) starts++;
            if (!rom_cs_n) begin
                cs_low++;
                if (rom_addr > max_a) max_a = rom_addr;
                if (prev_low && rom_addr == prev_a) begin
                    hold_len++;
                end else begin
                    if (prev_low && prev_a != 0 && hold_len != WAIT + 1) hold_bad++;
                    if (prev_low && rom_addr != prev_a + 1) seq_bad++;
                    hold_len = 1;
                end
                prev_a   = rom_addr;
                prev_low = 1'b1;
            end else begin
                if (prev_low && hold_len != WAIT + 1) hold_bad++;
                prev_low = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk); #1 mon_clr = 1'b1;
        @(negedge clk); #1 mon_clr = 1'b0;
    endtask

    task automatic do_reset(input logic sel);
        @(negedge clk); #1 rst = 1'b1; boot_sel = sel;
        repeat (4) @(negedge clk);
    endtask

    // returns posedges counted from release until core_start, or -1
    task automatic release_and_wait(input bit flip_sel, output int cyc);
        cyc = -1;
        #1 rst = 1'b0;
        for (int n = 1; n <= LOAD_CYC + 200; n++) begin
            @(posedge clk);
            if (flip_sel && n == 10) #1 boot_sel = ~boot_sel;
            @(negedge clk);
            if (core_start) begin cyc = n; break; end
        end
    endtask

    // word index, expected packed word (worked out by hand from R5)
    localparam logic [39:0] PROBE_TBL [6] = '{
        {8'd0,   32'h5958_5B5A},
        {8'd1,   32'h5D5C_5F5E},
        {8'd63,  32'hA5A4_A7A6},
        {8'd64,  32'h1918_1B1A},
        {8'd128, 32'hD9D8_DBDA},
        {8'd255, 32'h6564_6766}
    };

    logic wd_fired = 1'b0;
    initial begin
        repeat (150000) @(posedge clk);
        wd_fired = 1'b1;
    end

    initial begin : main
        int cyc;
        mon_clr = 1'b1;
        repeat (4) @(negedge clk);
        #1 mon_clr = 1'b0;

        // reset state (R3, R7)
        @(negedge clk);
        check(rom_cs_n == 1'b1, "R3 cs high in reset", rom_cs_n, 1);
        check(!imem_we && !core_start && !core_run, "R7 quiet in reset",
              {imem_we, core_start, core_run}, 0);

        // memory boot with boot_sel flipped after reset (R1, R2, R4..R7, R10)
        release_and_wait(1'b1, cyc);
        check(cyc == LOAD_CYC, "R10 load latency", cyc, LOAD_CYC);
        check(imem_we && imem_addr == 8'hFF, "R7 start with last write", imem_addr, 8'hFF);
        check(core_entry_pc == 32'h0, "R7 entry pc", core_entry_pc, 0);
        @(negedge clk);
        check(!core_start, "R7 start one cycle", core_start, 0);
        check(core_run, "R7 run held", core_run, 1);
        check(rom_cs_n, "R3 cs high after load", rom_cs_n, 1);
        check(wr_cnt == NWORDS, "R6 write count (R1 R2 boot taken)", wr_cnt, NWORDS);
        check(wr_bad == 0, "R6 R5 write order/data", wr_bad, 0);
        check(max_a == 24'd1023, "R4 top byte address", max_a, 1023);
        check(seq_bad == 0 && hold_bad == 0, "R4 ascending, held WAIT+1",
              {seq_bad, hold_bad}, 0);
        check(starts == 1, "R7 one start pulse", starts, 1);
        for (int i = 0; i < 6; i++) begin
            check(seen[PROBE_TBL[i][39:32]] == PROBE_TBL[i][31:0], "R5 packed word",
                  seen[PROBE_TBL[i][39:32]], PROBE_TBL[i][31:0]);
        end

        // idle path, boot_sel dropped after reset (R1, R2, R8)
        do_reset(1'b1);
        clear_mon();
        #1 rst = 1'b0;
        repeat (3) @(negedge clk);
        #1 boot_sel = 1'b0;
        repeat (300) @(negedge clk);
        check(cs_low == 0, "R1 R2 idle keeps cs high", cs_low, 0);
        check(wr_cnt == 0 && starts == 0 && !core_run, "R8 idle no writes/start",
              {wr_cnt, starts}, 0);

        // abort mid-load (R9)
        do_reset(1'b0);
        clear_mon();
        #1 rst = 1'b0;
        repeat (1000) @(negedge clk);
        check(wr_cnt > 0 && wr_cnt < NWORDS, "R9 partial load before abort", wr_cnt, 83);
        do_reset(1'b1);
        clear_mon();
        #1 rst = 1'b0;
        repeat (200) @(negedge clk);
        check(cs_low == 0 && wr_cnt == 0, "R9 resampled to idle", {cs_low, wr_cnt}, 0);
        do_reset(1'b0);
        clear_mon();
        release_and_wait(1'b0, cyc);
        @(negedge clk);
        check(cyc == LOAD_CYC, "R9 R10 fresh load latency", cyc, LOAD_CYC);
        check(wr_cnt == NWORDS && wr_bad == 0, "R9 restart from word 0",
              {wr_cnt, wr_bad}, NWORDS);

        if (wd_fired) check(1'b0, "watchdog", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (wd_fired);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule